// File: doc/BRIEF.md
# Remote DMA Channel Register Redirector

This block sits on the processor-facing target port of an I/O bridge and decides, for each access to a legacy DMA channel register, whether it is served locally or by a remote peripheral that now owns that channel. Local accesses complete at once against an internal legacy register file. A redirected access is refused with a retry on its first attempt. The block then arbitrates for the bus, runs a single I/O cycle to the peripheral at an address it computes, and keeps the outcome. It completes the access when the processor repeats it.

Channels form two groups: 0 to 3 (low) and 5 to 7 (high). Each group has a 10-bit base pointer and an enable, both supplied as inputs. Channel 4 is never redirected. While an operation is pending, any other processor access is refused with a retry.

Top module: `ddma_redirector`

## Requirements
- R1: A read or write that hits an enabled redirected channel while the block is idle is answered with retry high and ack low in the same cycle, and the local register file is not modified by it.
- R2: The block raises mst_req_o after issuing the retry and keeps it high until its master cycle ends. mst_valid_o stays low until a cycle in which mst_gnt_i is high while mst_req_o is high, and it rises on the next clock edge.
- R3: During a master cycle, the address has bits [31:16] at zero. Bits [15:6] hold base_lo_i for channels 0 to 3 or base_hi_i for channels 5 to 7. Bits [5:4] hold the channel number modulo 4.
- R4: Address bits [3:0] carry the peripheral register index, formed from the processor register index r as {r[1:0], r[3:2]}.
- R5: A repeated read that matches the pending one, after the master cycle, is acked. Its data is the peripheral read data ORed bitwise with the local register at the same channel and index.
- R6: For a redirected write, mst_we_o is high and mst_wdata_o equals the original write data. The local register at that channel and index takes the same data when mst_ready_i ends the master cycle. The repeated write is then acked.
- R7: While an operation is pending, any access is refused with retry high and ack low, and has no effect on the local register file. This covers a different channel, index or direction, a write with different data, or a local channel. The exception is the matching repeat after the data is ready.
- R8: Accesses to channel 4, or to a group whose enable is low, are acked in the same cycle without retry. Reads return the local register value. Writes update it at the next clock edge.
- R9: The active-low asynchronous reset returns the block to idle with mst_req_o and mst_valid_o low, and clears the buffered read data and every local register to zero.
- R10: While mst_valid_o is high and mst_ready_i is low, mst_valid_o, mst_addr_o and mst_wdata_o stay unchanged on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| base_lo_i | input | 10 | Base pointer for channels 0 to 3 |
| base_lo_en_i | input | 1 | Redirect enable for channels 0 to 3 |
| base_hi_i | input | 10 | Base pointer for channels 5 to 7 |
| base_hi_en_i | input | 1 | Redirect enable for channels 5 to 7 |
| tgt_req_i | input | 1 | Processor access strobe |
| tgt_we_i | input | 1 | Processor access is a write |
| tgt_chan_i | input | 3 | DMA channel number |
| tgt_reg_i | input | 4 | Register index within the channel |
| tgt_wdata_i | input | 8 | Processor write data |
| tgt_ack_o | output | 1 | Access completed this cycle |
| tgt_retry_o | output | 1 | Access refused, must be repeated |
| tgt_rdata_o | output | 8 | Read data returned with ack |
| mst_req_o | output | 1 | Bus request |
| mst_gnt_i | input | 1 | Bus grant |
| mst_valid_o | output | 1 | Master I/O cycle active |
| mst_we_o | output | 1 | Master cycle is a write |
| mst_addr_o | output | 32 | Master I/O address |
| mst_wdata_o | output | 8 | Master write data |
| mst_ready_i | input | 1 | Peripheral ends the master cycle |
| mst_rdata_i | input | 8 | Peripheral read data |

## Verification
Two functions can land on the same clock edge: a foreign processor access arriving while the master side advances. The bench raises an unrelated access in the very cycle it asserts mst_gnt_i, and again in the cycle it asserts mst_ready_i. The foreign access must get a retry and no ack, and the master transfer must proceed with an unchanged address. A later local read must show that the refused write left the register file untouched.

// File: rtl/ddma_pkg.sv
package ddma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RETRY_ISSUED,
    ST_BUS_REQUEST,
    ST_MASTER_CYCLE,
    ST_DATA_READY
  } ddma_state_e;

  // peripheral index layout differs from the legacy one: swap bit pairs
  function automatic logic [3:0] remap_reg(input logic [3:0] r);
    return {r[1:0], r[3:2]};
  endfunction
endpackage

// File: rtl/ddma_addr_gen.sv
module ddma_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int BASE_W = 10,
  parameter int CH_W   = 3,
  parameter int REG_W  = 4
) (
  input  logic [BASE_W-1:0] base_lo_i,
  input  logic [BASE_W-1:0] base_hi_i,
  input  logic [CH_W-1:0]   chan_i,
  input  logic [REG_W-1:0]  reg_i,
  output logic [ADDR_W-1:0] addr_o
);
  import ddma_pkg::*;
  localparam int SEL_W    = CH_W - 1;
  localparam int BASE_LSB = REG_W + SEL_W;

  always_comb begin
    addr_o = '0;
    addr_o[BASE_LSB +: BASE_W] = chan_i[CH_W-1] ? base_hi_i : base_lo_i;
    addr_o[REG_W +: SEL_W]     = chan_i[SEL_W-1:0];
    addr_o[REG_W-1:0]          = remap_reg(reg_i);
  end
endmodule

// File: rtl/ddma_local_regs.sv
module ddma_local_regs #(
  parameter int DATA_W  = 8,
  parameter int NUM_ENT = 128,
  localparam int IDX_W  = $clog2(NUM_ENT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  ridx_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem [NUM_ENT];

  for (genvar i = 0; i < NUM_ENT; i++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               mem[i] <= '0;
      else if (we_i && widx_i == IDX_W'(i))      mem[i] <= wdata_i;
    end
  end

  assign rdata_o = mem[ridx_i];
endmodule

// File: rtl/ddma_seq.sv
module ddma_seq
  import ddma_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tgt_req_i,
  input  logic        hit_i,
  input  logic        match_i,
  input  logic        mst_gnt_i,
  input  logic        mst_ready_i,
  output ddma_state_e state_o,
  output logic        load_o,
  output logic        done_o,
  output logic        ack_local_o,
  output logic        ack_remote_o,
  output logic        retry_o,
  output logic        mst_req_o,
  output logic        mst_valid_o
);
  ddma_state_e state_q, state_d;

  always_comb begin
    state_d      = state_q;
    load_o       = 1'b0;
    done_o       = 1'b0;
    ack_local_o  = 1'b0;
    ack_remote_o = 1'b0;
    retry_o      = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (tgt_req_i && hit_i) begin
          retry_o = 1'b1;
          load_o  = 1'b1;
          state_d = ST_RETRY_ISSUED;
        end else if (tgt_req_i) begin
          ack_local_o = 1'b1;
        end
      end
      ST_RETRY_ISSUED: begin
        retry_o = tgt_req_i;
        state_d = ST_BUS_REQUEST;
      end
      ST_BUS_REQUEST: begin
        retry_o = tgt_req_i;
        if (mst_gnt_i) state_d = ST_MASTER_CYCLE;
      end
      ST_MASTER_CYCLE: begin
        retry_o = tgt_req_i;
        if (mst_ready_i) begin
          done_o  = 1'b1;
          state_d = ST_DATA_READY;
        end
      end
      ST_DATA_READY: begin
        if (tgt_req_i && match_i) begin
          ack_remote_o = 1'b1;
          state_d      = ST_IDLE;
        end else begin
          retry_o = tgt_req_i;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o     = state_q;
  assign mst_req_o   = (state_q == ST_BUS_REQUEST) || (state_q == ST_MASTER_CYCLE);
  assign mst_valid_o = (state_q == ST_MASTER_CYCLE);

  assert_ack_retry_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(retry_o && (ack_local_o || ack_remote_o)));
  assert_valid_after_grant_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mst_valid_o) |-> $past(mst_gnt_i && mst_req_o));
  assert_valid_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mst_valid_o && !mst_ready_i |=> mst_valid_o);
  assert_remote_ack_after_cycle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mst_valid_o && mst_ready_i |=> !mst_req_o && !mst_valid_o);
endmodule

// File: rtl/ddma_redirector.sv
module ddma_redirector
  import ddma_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int BASE_W  = 10,
  parameter int DATA_W  = 8,
  parameter int CH_W    = 3,
  parameter int REG_W   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BASE_W-1:0] base_lo_i,
  input  logic              base_lo_en_i,
  input  logic [BASE_W-1:0] base_hi_i,
  input  logic              base_hi_en_i,
  input  logic              tgt_req_i,
  input  logic              tgt_we_i,
  input  logic [CH_W-1:0]   tgt_chan_i,
  input  logic [REG_W-1:0]  tgt_reg_i,
  input  logic [DATA_W-1:0] tgt_wdata_i,
  output logic              tgt_ack_o,
  output logic              tgt_retry_o,
  output logic [DATA_W-1:0] tgt_rdata_o,
  output logic              mst_req_o,
  input  logic              mst_gnt_i,
  output logic              mst_valid_o,
  output logic              mst_we_o,
  output logic [ADDR_W-1:0] mst_addr_o,
  output logic [DATA_W-1:0] mst_wdata_o,
  input  logic              mst_ready_i,
  input  logic [DATA_W-1:0] mst_rdata_i
);
  localparam int NUM_ENT = (1 << CH_W) * (1 << REG_W);
  localparam int IDX_W   = CH_W + REG_W;
  localparam int SEL_W   = CH_W - 1;

  ddma_state_e       state;
  logic              hit, match, load, done, ack_local, ack_remote;
  logic              p_we;
  logic [CH_W-1:0]   p_chan;
  logic [REG_W-1:0]  p_reg;
  logic [DATA_W-1:0] p_wdata, rbuf, loc_rdata;
  logic              loc_we;
  logic [IDX_W-1:0]  loc_widx;
  logic [DATA_W-1:0] loc_wdata;

  // channel 4 (upper group, sel 0) is the cascade slot and stays local
  always_comb begin
    if (!tgt_chan_i[CH_W-1]) hit = base_lo_en_i;
    else                     hit = base_hi_en_i && (tgt_chan_i[SEL_W-1:0] != '0);
  end

  assign match = (tgt_we_i == p_we) && (tgt_chan_i == p_chan) && (tgt_reg_i == p_reg) &&
                 (!p_we || (tgt_wdata_i == p_wdata));

  ddma_seq u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tgt_req_i    (tgt_req_i),
    .hit_i        (hit),
    .match_i      (match),
    .mst_gnt_i    (mst_gnt_i),
    .mst_ready_i  (mst_ready_i),
    .state_o      (state),
    .load_o       (load),
    .done_o       (done),
    .ack_local_o  (ack_local),
    .ack_remote_o (ack_remote),
    .retry_o      (tgt_retry_o),
    .mst_req_o    (mst_req_o),
    .mst_valid_o  (mst_valid_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      p_we    <= 1'b0;
      p_chan  <= '0;
      p_reg   <= '0;
      p_wdata <= '0;
    end else if (load) begin
      p_we    <= tgt_we_i;
      p_chan  <= tgt_chan_i;
      p_reg   <= tgt_reg_i;
      p_wdata <= tgt_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             rbuf <= '0;
    else if (done && !p_we)  rbuf <= mst_rdata_i;
  end

  // local file: immediate writes for pass-through, deferred mirror for redirected writes
  assign loc_we    = (ack_local && tgt_we_i) || (done && p_we);
  assign loc_widx  = done ? {p_chan, p_reg} : {tgt_chan_i, tgt_reg_i};
  assign loc_wdata = done ? p_wdata : tgt_wdata_i;

  ddma_local_regs #(.DATA_W(DATA_W), .NUM_ENT(NUM_ENT)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (loc_we),
    .widx_i  (loc_widx),
    .wdata_i (loc_wdata),
    .ridx_i  ({tgt_chan_i, tgt_reg_i}),
    .rdata_o (loc_rdata)
  );

  ddma_addr_gen #(.ADDR_W(ADDR_W), .BASE_W(BASE_W), .CH_W(CH_W), .REG_W(REG_W)) u_addr (
    .base_lo_i (base_lo_i),
    .base_hi_i (base_hi_i),
    .chan_i    (p_chan),
    .reg_i     (p_reg),
    .addr_o    (mst_addr_o)
  );

  assign mst_we_o    = p_we;
  assign mst_wdata_o = p_wdata;
  assign tgt_ack_o   = ack_local || ack_remote;

  always_comb begin
    tgt_rdata_o = '0;
    if (ack_remote && !p_we)     tgt_rdata_o = rbuf | loc_rdata;
    else if (ack_local && !tgt_we_i) tgt_rdata_o = loc_rdata;
  end

  assert_addr_upper_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mst_valid_o |-> mst_addr_o[ADDR_W-1:16] == '0);
  assert_addr_stable_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mst_valid_o && !mst_ready_i |=> $stable(mst_addr_o) && $stable(mst_wdata_o) && $stable(mst_we_o));
  assert_req_covers_valid_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mst_valid_o |-> mst_req_o);
  assert_busy_no_local_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_retry_o |-> !(ack_local && tgt_we_i));
  assert_first_hit_retry_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mst_req_o) |-> $past(tgt_retry_o, 2));
endmodule

// File: tb/ddma_redirector_tb.sv
module ddma_redirector_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic [9:0] base_lo = '0, base_hi = '0;
  logic en_lo = 1'b0, en_hi = 1'b0;
  logic tgt_req = 1'b0, tgt_we = 1'b0;
  logic [2:0] tgt_chan = '0;
  logic [3:0] tgt_reg = '0;
  logic [7:0] tgt_wdata = '0;
  logic tgt_ack, tgt_retry;
  logic [7:0] tgt_rdata;
  logic mst_req, mst_gnt = 1'b0, mst_valid, mst_we, mst_ready = 1'b0;
  logic [31:0] mst_addr;
  logic [7:0] mst_wdata, mst_rdata = '0;

  int checks = 0, errors = 0;
  bit done_flag = 0;
  logic [7:0] model [128];

  always #(CLK_PERIOD/2) clk = ~clk;

  ddma_redirector u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .base_lo_i(base_lo), .base_lo_en_i(en_lo), .base_hi_i(base_hi), .base_hi_en_i(en_hi),
    .tgt_req_i(tgt_req), .tgt_we_i(tgt_we), .tgt_chan_i(tgt_chan), .tgt_reg_i(tgt_reg),
    .tgt_wdata_i(tgt_wdata), .tgt_ack_o(tgt_ack), .tgt_retry_o(tgt_retry), .tgt_rdata_o(tgt_rdata),
    .mst_req_o(mst_req), .mst_gnt_i(mst_gnt), .mst_valid_o(mst_valid), .mst_we_o(mst_we),
    .mst_addr_o(mst_addr), .mst_wdata_o(mst_wdata), .mst_ready_i(mst_ready), .mst_rdata_i(mst_rdata)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic bit is_redir(input logic [2:0] ch, input logic elo, input logic ehi);
    if (ch < 4) return elo;
    return ehi && (ch != 3'd4);
  endfunction

  function automatic logic [31:0] exp_addr(input logic [2:0] ch, input logic [3:0] rg);
    return {16'h0, (ch[2] ? base_hi : base_lo), ch[1:0], rg[1:0], rg[3:2]};
  endfunction

  task automatic clear_model();
    for (int i = 0; i < 128; i++) model[i] = '0;
  endtask

  task automatic set_tgt(input logic we, input logic [2:0] ch, input logic [3:0] rg, input logic [7:0] wd);
    tgt_req = 1'b1; tgt_we = we; tgt_chan = ch; tgt_reg = rg; tgt_wdata = wd;
  endtask

  // one access cycle; result sampled before the edge
  task automatic pulse(input logic we, input logic [2:0] ch, input logic [3:0] rg, input logic [7:0] wd,
                       output logic ack, output logic retry, output logic [7:0] rd);
    @(negedge clk);
    set_tgt(we, ch, rg, wd);
    #1;
    ack = tgt_ack; retry = tgt_retry; rd = tgt_rdata;
    @(posedge clk);
    #1 tgt_req = 1'b0;
  endtask

  task automatic local_acc(input logic we, input logic [2:0] ch, input logic [3:0] rg, input logic [7:0] wd);
    logic a, r;
    logic [7:0] d;
    pulse(we, ch, rg, wd, a, r, d);
    chk(a && !r, "R8 local ack", {a, r}, 2'b10);
    if (we) model[{ch, rg}] = wd;
    else    chk(d == model[{ch, rg}], "R8 local read data", d, model[{ch, rg}]);
  endtask

  task automatic foreign(input logic [2:0] ch, input logic [3:0] rg);
    set_tgt($urandom_range(0, 1), ch, rg ^ 4'h1, 8'($urandom));
  endtask

  task automatic redir(input logic we, input logic [2:0] ch, input logic [3:0] rg, input logic [7:0] wd,
                       input bit busy_hits);
    logic a, r;
    logic [7:0] d, prd;
    logic [31:0] ea;
    int n;
    ea = exp_addr(ch, rg);
    pulse(we, ch, rg, wd, a, r, d);
    chk(r && !a, "R1 first access retried", {a, r}, 2'b01);
    n = 0;
    while (!mst_req && n < 6) begin
      @(negedge clk); #1;
      chk(!mst_valid, "R2 no cycle before request", mst_valid, 0);
      n++;
    end
    chk(mst_req, "R2 request raised", mst_req, 1);
    repeat ($urandom_range(0, 3)) begin
      @(negedge clk); #1;
      chk(!mst_valid && mst_req, "R2 wait for grant", {mst_req, mst_valid}, 2'b10);
    end
    // grant, possibly together with an unrelated access
    @(negedge clk);
    mst_gnt = 1'b1;
    if (busy_hits) foreign(ch, rg);
    #1;
    if (busy_hits) chk(tgt_retry && !tgt_ack, "R7 busy access at grant", {tgt_ack, tgt_retry}, 2'b01);
    @(posedge clk);
    #1 mst_gnt = 1'b0; tgt_req = 1'b0;
    chk(mst_valid && mst_req, "R2 cycle after grant", {mst_req, mst_valid}, 2'b11);
    chk(mst_addr[31:4] == ea[31:4], "R3 address upper fields", mst_addr, ea);
    chk(mst_addr[3:0] == ea[3:0], "R4 register remap", mst_addr[3:0], ea[3:0]);
    chk(mst_we == we, "R6 master direction", mst_we, we);
    if (we) chk(mst_wdata == wd, "R6 master write data", mst_wdata, wd);
    repeat ($urandom_range(0, 2)) begin
      @(negedge clk); #1;
      chk(mst_valid && mst_addr == ea && mst_wdata == wd || (mst_valid && !we && mst_addr == ea),
          "R10 held while not ready", mst_addr, ea);
    end
    prd = 8'($urandom);
    @(negedge clk);
    mst_ready = 1'b1; mst_rdata = prd;
    if (busy_hits) foreign(3'($urandom), rg);
    #1;
    if (busy_hits) chk(tgt_retry && !tgt_ack, "R7 busy access at ready", {tgt_ack, tgt_retry}, 2'b01);
    @(posedge clk);
    #1 mst_ready = 1'b0; tgt_req = 1'b0;
    if (we) model[{ch, rg}] = wd;
    chk(!mst_req && !mst_valid, "R2 request dropped", {mst_req, mst_valid}, 2'b00);
    if (busy_hits) begin
      pulse(we, ch, rg ^ 4'h2, wd, a, r, d);
      chk(r && !a, "R7 non-matching repeat", {a, r}, 2'b01);
      if (we) begin
        pulse(we, ch, rg, wd ^ 8'h5a, a, r, d);
        chk(r && !a, "R7 write data mismatch", {a, r}, 2'b01);
      end
    end
    pulse(we, ch, rg, wd, a, r, d);
    if (we) chk(a && !r, "R6 repeated write completes", {a, r}, 2'b10);
    else begin
      chk(a && !r, "R5 repeated read completes", {a, r}, 2'b10);
      chk(d == (prd | model[{ch, rg}]), "R5 merged read data", d, prd | model[{ch, rg}]);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic a, r;
    logic [7:0] d;
    clear_model();
    repeat (3) @(posedge clk);
    #1;
    chk(!mst_req && !mst_valid, "R9 reset outputs", {mst_req, mst_valid}, 0);
    @(negedge clk) rst_ni = 1'b1;
    local_acc(0, 3'd2, 4'h7, 8'h00);

    // directed: pass-through, disabled groups and cascade channel
    local_acc(1, 3'd1, 4'h2, 8'h3c);
    local_acc(0, 3'd1, 4'h2, 8'h00);
    en_lo = 1'b1; en_hi = 1'b1; base_lo = 10'h2a5; base_hi = 10'h15a;
    local_acc(1, 3'd4, 4'hb, 8'h81);
    local_acc(0, 3'd4, 4'hb, 8'h00);

    // directed redirected read merging local bits, then write
    redir(0, 3'd1, 4'h2, 8'h00, 1);
    redir(1, 3'd5, 4'h9, 8'hc3, 1);
    redir(0, 3'd7, 4'hf, 8'h00, 0);
    redir(1, 3'd0, 4'h0, 8'he7, 0);
    en_lo = 1'b0;
    local_acc(0, 3'd0, 4'h0, 8'h00);

    // random mix
    for (int it = 0; it < 60; it++) begin
      logic [2:0] ch;
      logic [3:0] rg;
      logic we;
      logic [7:0] wd;
      @(negedge clk);
      en_lo = $urandom_range(0, 1); en_hi = $urandom_range(0, 1);
      base_lo = 10'($urandom); base_hi = 10'($urandom);
      ch = 3'($urandom); rg = 4'($urandom); we = $urandom_range(0, 1); wd = 8'($urandom);
      if (is_redir(ch, en_lo, en_hi)) redir(we, ch, rg, wd, $urandom_range(0, 1));
      else                            local_acc(we, ch, rg, wd);
    end

    // refused writes must not have touched the local file
    @(negedge clk);
    en_lo = 1'b0; en_hi = 1'b0;
    for (int i = 0; i < 128; i++) local_acc(0, 3'(i >> 4), 4'(i), 8'h00);

    // reset while an operation is pending
    en_lo = 1'b1; base_lo = 10'h0f0;
    pulse(0, 3'd2, 4'h3, 8'h00, a, r, d);
    chk(r, "R1 retry before reset", r, 1);
    repeat (3) @(negedge clk);
    rst_ni = 1'b0;
    #1;
    chk(!mst_req && !mst_valid, "R9 reset aborts request", {mst_req, mst_valid}, 0);
    @(negedge clk) rst_ni = 1'b1;
    clear_model();
    en_lo = 1'b0;
    local_acc(0, 3'd5, 4'h9, 8'h00);
    local_acc(0, 3'd1, 4'h2, 8'h00);
    en_lo = 1'b1;
    redir(0, 3'd2, 4'h3, 8'h00, 0);

    done_flag = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule